// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves blocks of data between an I/O device and memory while the processor is held off the bus. The processor programs each of four channels with a transfer direction, a start memory address and an item count. A channel's number also selects the device it serves, because each channel has its own request and acknowledge pair. When a programmed channel's device asks for service, the controller requests the bus from the processor. Once the processor grants the bus, the controller acknowledges the device and runs read/write strobe pairs, one pair per item. The data word goes straight from the source to the destination and is never stored in the controller.

Each item takes three cycles: an address setup cycle, a read cycle and a read-plus-write cycle. After every item the channel's address goes up by one and its count goes down by one. When the count reaches zero, the controller releases the bus and pulses a completion interrupt that carries the channel number. If a device withdraws its request partway through a block, the current item still finishes and the bus is released. The channel keeps its place and continues on the device's next request.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: During reset and after it, every output is low and no channel is armed. An unprogrammed channel's device request does not raise the bus request.
- R2: A configuration write loads direction (0 = memory to device, 1 = device to memory), address and count into channel `cfg_ch_i`. A channel with count 0 stays idle. A write to the channel that currently owns the bus is ignored.
- R3: The bus request rises in the cycle after an armed channel's device request is seen, provided the bus acknowledge is low. No new bus request starts while the acknowledge from the previous tenure is still high.
- R4: Until the bus acknowledge has been received, the controller drives no strobe and no device acknowledge, and `addr_o` stays 0. The bus request stays high across all items of an uninterrupted block.
- R5: In the cycles of an item, `dev_ack_o` is one-hot, and bit i marks channel i. Outside those cycles it is zero.
- R6: In direction 0, an item is an address cycle, then a cycle with `mem_rd_o`, then a cycle with `mem_rd_o` and `io_wr_o`. In direction 1, the strobes are `io_rd_o` and then `io_rd_o` with `mem_wr_o`. No strobe is active in the cycle after a write strobe.
- R7: Items go to consecutive addresses starting at the programmed address, and their number equals the programmed count.
- R8: On the item that brings the count to zero, the bus request drops and `done_irq_o` is high for exactly one cycle, with `done_ch_o` set to the channel number.
- R9: Among simultaneous requests, the lowest-numbered channel wins. The winner is chosen when the acknowledge arrives, and it keeps the bus until its count reaches zero, even if a higher-priority channel asks meanwhile.
- R10: If a device request drops during a block, the current item completes and the bus request falls. Address and count are kept, and the next request resumes at the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Channel configuration write strobe |
| cfg_ch_i | input | 2 | Channel being programmed |
| cfg_dir_i | input | 1 | Direction: 0 memory to device, 1 device to memory |
| cfg_addr_i | input | AW (16) | Start memory address |
| cfg_cnt_i | input | CW (16) | Number of items |
| dev_req_i | input | 4 | Per-channel device service request |
| dev_ack_o | output | 4 | Per-channel device acknowledge |
| hold_req_o | output | 1 | Bus request to the processor |
| hold_ack_i | input | 1 | Bus granted by the processor |
| addr_o | output | AW (16) | Memory address during an item |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Device read strobe |
| io_wr_o | output | 1 | Device write strobe |
| done_irq_o | output | 1 | One-cycle completion interrupt |
| done_ch_o | output | 2 | Channel that completed |

## Verification
Two events can fall in the same cycle: the final item of a block completing, and the device withdrawing its request. The bench lowers the request in the very cycle of the last write strobe. It then expects a completion interrupt rather than a resumable pause, and it expects later requests from that device to be ignored. A second collision is a configuration write aimed at the channel in the middle of its block. The write lands in a write-strobe cycle, and the bench expects the remaining items to continue at the old addresses and count.

// File: rtl/dma_flyby_pkg.sv
package dma_flyby_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_HOLD  = 3'd1,
        SQ_SETUP = 3'd2,
        SQ_READ  = 3'd3,
        SQ_XFER  = 3'd4
    } sq_state_e;

    localparam logic XF_MEM2IO = 1'b0;
    localparam logic XF_IO2MEM = 1'b1;

endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    cfg_we_i,
    input  logic [CHW-1:0]          cfg_ch_i,
    input  logic                    cfg_dir_i,
    input  logic [AW-1:0]           cfg_addr_i,
    input  logic [CW-1:0]           cfg_cnt_i,
    input  logic                    lock_i,
    input  logic [CHW-1:0]          lock_ch_i,
    input  logic                    step_i,
    output logic [NCH-1:0]          armed_o,
    output logic [NCH-1:0]          last_o,
    output logic [NCH-1:0]          dir_o,
    output logic [NCH-1:0][AW-1:0]  addr_o
);

    typedef struct packed {
        logic          dir;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } chan_t;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_t chan_d, chan_q;
        logic  hit_cfg, hit_step;

        always_comb begin
            chan_d   = chan_q;
            hit_cfg  = cfg_we_i && (cfg_ch_i == CHW'(g))
                       && !(lock_i && (lock_ch_i == CHW'(g)));
            hit_step = step_i && lock_i && (lock_ch_i == CHW'(g));
            if (hit_cfg) begin
                chan_d.dir  = cfg_dir_i;
                chan_d.addr = cfg_addr_i;
                chan_d.cnt  = cfg_cnt_i;
            end else if (hit_step) begin
                chan_d.addr = chan_q.addr + 1'b1;
                chan_d.cnt  = chan_q.cnt - 1'b1;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chan_q <= '0;
            else         chan_q <= chan_d;
        end

        assign armed_o[g] = |chan_q.cnt;
        assign last_o[g]  = (chan_q.cnt == CW'(1));
        assign dir_o[g]   = chan_q.dir;
        assign addr_o[g]  = chan_q.addr;
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req_i,
    output logic           valid_o,
    output logic [CHW-1:0] idx_o
);

    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = CHW'(i);
        end
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_flyby_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    hold_ack_i,
    input  logic [NCH-1:0]          dev_req_i,
    input  logic [NCH-1:0]          pend_i,
    input  logic                    pick_valid_i,
    input  logic [CHW-1:0]          pick_idx_i,
    input  logic [NCH-1:0]          last_i,
    input  logic [NCH-1:0]          dir_i,
    input  logic [NCH-1:0][AW-1:0]  addr_i,
    output logic                    hold_req_o,
    output logic [NCH-1:0]          dev_ack_o,
    output logic [AW-1:0]           addr_o,
    output logic                    mem_rd_o,
    output logic                    mem_wr_o,
    output logic                    io_rd_o,
    output logic                    io_wr_o,
    output logic                    done_irq_o,
    output logic [CHW-1:0]          done_ch_o,
    output logic                    lock_o,
    output logic [CHW-1:0]          lock_ch_o,
    output logic                    step_o
);

    typedef struct packed {
        sq_state_e      state;
        logic [CHW-1:0] ch;
        logic           irq;
        logic [CHW-1:0] irq_ch;
    } seq_t;

    seq_t seq_d, seq_q;
    logic bus_ph, rd_ph, wr_ph, cur_dir;

    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = 1'b0;
        step_o    = 1'b0;
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (!hold_ack_i && (|pend_i)) seq_d.state = SQ_HOLD;
            end
            SQ_HOLD: begin
                if (hold_ack_i) begin
                    if (pick_valid_i) begin
                        seq_d.ch    = pick_idx_i;
                        seq_d.state = SQ_SETUP;
                    end else begin
                        seq_d.state = SQ_IDLE;
                    end
                end
            end
            SQ_SETUP: seq_d.state = SQ_READ;
            SQ_READ:  seq_d.state = SQ_XFER;
            SQ_XFER: begin
                step_o = 1'b1;
                if (last_i[seq_q.ch]) begin
                    seq_d.state  = SQ_IDLE;
                    seq_d.irq    = 1'b1;
                    seq_d.irq_ch = seq_q.ch;
                end else if (dev_req_i[seq_q.ch]) begin
                    seq_d.state = SQ_SETUP;
                end else begin
                    seq_d.state = SQ_IDLE;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    always_comb begin
        bus_ph  = (seq_q.state == SQ_SETUP) || (seq_q.state == SQ_READ)
                  || (seq_q.state == SQ_XFER);
        rd_ph   = (seq_q.state == SQ_READ) || (seq_q.state == SQ_XFER);
        wr_ph   = (seq_q.state == SQ_XFER);
        cur_dir = dir_i[seq_q.ch];
    end

    assign hold_req_o = (seq_q.state != SQ_IDLE);
    assign dev_ack_o  = bus_ph ? (NCH'(1) << seq_q.ch) : '0;
    assign addr_o     = bus_ph ? addr_i[seq_q.ch] : '0;
    assign mem_rd_o   = rd_ph && (cur_dir == XF_MEM2IO);
    assign io_wr_o    = wr_ph && (cur_dir == XF_MEM2IO);
    assign io_rd_o    = rd_ph && (cur_dir == XF_IO2MEM);
    assign mem_wr_o   = wr_ph && (cur_dir == XF_IO2MEM);
    assign done_irq_o = seq_q.irq;
    assign done_ch_o  = seq_q.irq_ch;
    assign lock_o     = bus_ph;
    assign lock_ch_o  = seq_q.ch;

endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cfg_we_i,
    input  logic [CHW-1:0]  cfg_ch_i,
    input  logic            cfg_dir_i,
    input  logic [AW-1:0]   cfg_addr_i,
    input  logic [CW-1:0]   cfg_cnt_i,
    input  logic [NCH-1:0]  dev_req_i,
    output logic [NCH-1:0]  dev_ack_o,
    output logic            hold_req_o,
    input  logic            hold_ack_i,
    output logic [AW-1:0]   addr_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            io_rd_o,
    output logic            io_wr_o,
    output logic            done_irq_o,
    output logic [CHW-1:0]  done_ch_o
);

    logic [NCH-1:0]         armed, last, dir, pend;
    logic [NCH-1:0][AW-1:0] ch_addr;
    logic                   pick_valid, lock, step;
    logic [CHW-1:0]         pick_idx, lock_ch;

    assign pend = armed & dev_req_i;

    dma_chan_bank #(.NCH(NCH), .AW(AW), .CW(CW)) bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_we_i   (cfg_we_i),
        .cfg_ch_i   (cfg_ch_i),
        .cfg_dir_i  (cfg_dir_i),
        .cfg_addr_i (cfg_addr_i),
        .cfg_cnt_i  (cfg_cnt_i),
        .lock_i     (lock),
        .lock_ch_i  (lock_ch),
        .step_i     (step),
        .armed_o    (armed),
        .last_o     (last),
        .dir_o      (dir),
        .addr_o     (ch_addr)
    );

    dma_prio_pick #(.NCH(NCH)) pick_i (
        .req_i   (pend),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    dma_seq #(.NCH(NCH), .AW(AW)) seq_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .hold_ack_i   (hold_ack_i),
        .dev_req_i    (dev_req_i),
        .pend_i       (pend),
        .pick_valid_i (pick_valid),
        .pick_idx_i   (pick_idx),
        .last_i       (last),
        .dir_i        (dir),
        .addr_i       (ch_addr),
        .hold_req_o   (hold_req_o),
        .dev_ack_o    (dev_ack_o),
        .addr_o       (addr_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .io_rd_o      (io_rd_o),
        .io_wr_o      (io_wr_o),
        .done_irq_o   (done_irq_o),
        .done_ch_o    (done_ch_o),
        .lock_o       (lock),
        .lock_ch_o    (lock_ch),
        .step_o       (step)
    );

endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [NCH-1:0] dev_ack_o,
    input logic           hold_req_o,
    input logic           hold_ack_i,
    input logic [AW-1:0]  addr_o,
    input logic           mem_rd_o,
    input logic           mem_wr_o,
    input logic           io_rd_o,
    input logic           io_wr_o,
    input logic           done_irq_o
);

    // R3
    req_after_ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hold_req_o) |-> !$past(hold_ack_i));

    // R4
    bus_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|dev_ack_o) |-> (hold_ack_i && hold_req_o));

    // R4
    strobe_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |-> (|dev_ack_o));

    // R5
    ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(dev_ack_o));

    // R6
    mem2io_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        io_wr_o |-> (mem_rd_o && !io_rd_o && !mem_wr_o));

    // R6
    io2mem_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_o |-> (io_rd_o && !mem_rd_o && !io_wr_o));

    // R6
    item_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_wr_o || mem_wr_o) |=> !(mem_rd_o || mem_wr_o || io_rd_o || io_wr_o));

    // R7
    addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|dev_ack_o) && $past(io_wr_o || mem_wr_o))
        |-> ((addr_o == $past(addr_o) + 1'b1) && $stable(dev_ack_o)));

    // R8
    irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_irq_o |-> (!hold_req_o && $past(io_wr_o || mem_wr_o)));

endmodule

bind dma_flyby_ctrl dma_flyby_chk #(.NCH(NCH), .AW(AW)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_ack_o  (dev_ack_o),
    .hold_req_o (hold_req_o),
    .hold_ack_i (hold_ack_i),
    .addr_o     (addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .io_rd_o    (io_rd_o),
    .io_wr_o    (io_wr_o),
    .done_irq_o (done_irq_o)
);

// File: tb/dma_flyby_ctrl_tb_top.sv
module dma_flyby_ctrl_tb_top;

    typedef struct {
        int unsigned ch;
        bit          dir;
        int unsigned addr;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic        cfg_dir = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [15:0] cfg_cnt = '0;
    logic [3:0]  dev_req = '0;
    logic [3:0]  dev_ack;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic        ack_block = 1'b0;
    logic [15:0] addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, done_irq;
    logic [1:0]  done_ch;

    item_t       exp_q[$];
    int unsigned irq_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          irq_seen = 0;
    int          irq_tgt = 0;
    logic        prev_mem_rd = 1'b0, prev_io_rd = 1'b0, prev_wr = 1'b0;

    always #2 clk = ~clk;

    dma_flyby_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cfg_we_i   (cfg_we),
        .cfg_ch_i   (cfg_ch),
        .cfg_dir_i  (cfg_dir),
        .cfg_addr_i (cfg_addr),
        .cfg_cnt_i  (cfg_cnt),
        .dev_req_i  (dev_req),
        .dev_ack_o  (dev_ack),
        .hold_req_o (hold_req),
        .hold_ack_i (hold_ack),
        .addr_o     (addr),
        .mem_rd_o   (mem_rd),
        .mem_wr_o   (mem_wr),
        .io_rd_o    (io_rd),
        .io_wr_o    (io_wr),
        .done_irq_o (done_irq),
        .done_ch_o  (done_ch)
    );

    // processor model: grants the bus one cycle after the request
    always @(posedge clk) begin
        hold_ack <= rst_n && hold_req && !ack_block;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic prog(input int ch, input bit dir, input int a, input int n);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_ch   = 2'(ch);
        cfg_dir  = dir;
        cfg_addr = 16'(a);
        cfg_cnt  = 16'(n);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic expect_block(input int ch, input bit dir, input int a, input int n);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.ch = ch; it.dir = dir; it.addr = (a + i) & 16'hFFFF;
            exp_q.push_back(it);
        end
        irq_q.push_back(ch);
        irq_tgt++;
    endtask

    task automatic wait_irq(input string tag);
        int g = 0;
        while (irq_seen < irq_tgt && g < 3000) begin
            @(negedge clk);
            g++;
        end
        chk(irq_seen >= irq_tgt, tag, irq_seen, irq_tgt);
    endtask

    task automatic wait_wr();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!(io_wr || mem_wr) && g < 500);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (io_wr || mem_wr) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected item", int'(addr), 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(dev_ack == 4'(1 << e.ch), "R5 ack channel", int'(dev_ack), 1 << e.ch);
                    chk(int'(addr) == e.addr, "R7 item address", int'(addr), e.addr);
                    if (!e.dir)
                        chk(mem_rd && io_wr && prev_mem_rd && !prev_wr,
                            "R6 mem->io strobes", {io_wr, mem_rd, prev_mem_rd}, 3'b111);
                    else
                        chk(io_rd && mem_wr && prev_io_rd && !prev_wr,
                            "R6 io->mem strobes", {mem_wr, io_rd, prev_io_rd}, 3'b111);
                end
            end
            if (done_irq) begin
                irq_seen++;
                if (irq_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected irq", int'(done_ch), 0);
                end else begin
                    int unsigned c;
                    c = irq_q.pop_front();
                    chk(int'(done_ch) == int'(c), "R8 irq channel", int'(done_ch), c);
                    chk(!hold_req, "R8 bus released at irq", int'(hold_req), 0);
                end
            end
            prev_mem_rd = mem_rd;
            prev_io_rd  = io_rd;
            prev_wr     = io_wr || mem_wr;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk({dev_ack, hold_req, addr, mem_rd, mem_wr, io_rd, io_wr, done_irq} == '0,
            "R1 outputs in reset", int'(hold_req), 0);
        rst_n = 1'b1;
        dev_req = 4'b0100;
        repeat (6) @(negedge clk);
        chk(!hold_req && dev_ack == '0, "R1 unprogrammed channel idle", int'(hold_req), 0);
        dev_req = '0;

        // R3 R4 R5 R6 R7 R8: channel 1, memory to device, three items
        prog(1, 1'b0, 16'h0100, 3);
        expect_block(1, 1'b0, 16'h0100, 3);
        dev_req[1] = 1'b1;
        @(negedge clk);
        chk(hold_req, "R3 request one cycle after device", int'(hold_req), 1);
        chk(dev_ack == '0, "R4 no ack before grant", int'(dev_ack), 0);
        @(negedge clk);
        @(negedge clk);
        chk(dev_ack == 4'b0010, "R5 ack after grant", int'(dev_ack), 2);
        chk(!(mem_rd || io_wr) && addr == 16'h0100, "R6 setup cycle",
            int'(addr), 16'h0100);
        wait_irq("R8 block one irq");
        dev_req = '0;

        // R4 grant withheld
        ack_block = 1'b1;
        prog(0, 1'b1, 16'h0010, 1);
        expect_block(0, 1'b1, 16'h0010, 1);
        dev_req[0] = 1'b1;
        repeat (8) @(negedge clk);
        chk(hold_req && dev_ack == '0 && addr == '0 && !(mem_rd || mem_wr || io_rd || io_wr),
            "R4 nothing driven without grant", int'(dev_ack), 0);
        ack_block = 1'b0;
        wait_irq("R4 irq after late grant");
        dev_req = '0;

        // R7 device to memory, four items
        prog(2, 1'b1, 16'h2000, 4);
        expect_block(2, 1'b1, 16'h2000, 4);
        dev_req[2] = 1'b1;
        wait_irq("R7 four item block");
        dev_req = '0;

        // R9 simultaneous requests, channel 0 first
        prog(3, 1'b1, 16'h0300, 2);
        prog(0, 1'b0, 16'h0040, 2);
        expect_block(0, 1'b0, 16'h0040, 2);
        expect_block(3, 1'b1, 16'h0300, 2);
        dev_req = 4'b1001;
        wait_irq("R9 both blocks done");
        dev_req = '0;

        // R9 latched winner not preempted
        prog(2, 1'b0, 16'h0600, 3);
        prog(0, 1'b1, 16'h0080, 1);
        expect_block(2, 1'b0, 16'h0600, 3);
        expect_block(0, 1'b1, 16'h0080, 1);
        dev_req[2] = 1'b1;
        wait_wr();
        dev_req[0] = 1'b1;
        wait_irq("R9 latched channel kept bus");
        dev_req = '0;

        // R10 pause and resume
        prog(1, 1'b0, 16'h0500, 4);
        expect_block(1, 1'b0, 16'h0500, 4);
        dev_req[1] = 1'b1;
        wait_wr();
        dev_req[1] = 1'b0;
        repeat (4) @(negedge clk);
        chk(!hold_req, "R10 bus released on request drop", int'(hold_req), 0);
        chk(exp_q.size() == 3, "R10 one item before pause", exp_q.size(), 3);
        chk(irq_seen == irq_tgt - 1, "R10 no irq on pause", irq_seen, irq_tgt - 1);
        dev_req[1] = 1'b1;
        wait_irq("R10 resumed block done");
        dev_req = '0;

        // R2 write to active channel ignored
        prog(2, 1'b0, 16'h0700, 3);
        expect_block(2, 1'b0, 16'h0700, 3);
        dev_req[2] = 1'b1;
        wait_wr();
        cfg_we = 1'b1; cfg_ch = 2'd2; cfg_dir = 1'b1; cfg_addr = 16'h07F0; cfg_cnt = 16'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_irq("R2 active channel write ignored");
        dev_req = '0;

        // R2 zero count stays idle
        prog(3, 1'b0, 16'h0900, 0);
        dev_req[3] = 1'b1;
        repeat (6) @(negedge clk);
        chk(!hold_req, "R2 zero count idle", int'(hold_req), 0);
        dev_req = '0;

        // R8 R10 request drops on the final item: terminal wins
        prog(1, 1'b1, 16'hFFFF, 2);
        expect_block(1, 1'b1, 16'hFFFF, 2);
        dev_req[1] = 1'b1;
        wait_wr();
        wait_wr();
        dev_req[1] = 1'b0;
        wait_irq("R8 terminal with request drop");
        dev_req[1] = 1'b1;
        repeat (6) @(negedge clk);
        chk(!hold_req, "R8 exhausted channel idle", int'(hold_req), 0);
        dev_req = '0;

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all items seen", exp_q.size(), 0);
        chk(irq_q.size() == 0, "R8 all irqs seen", irq_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule